// File: doc/BRIEF.md
# Bank Precharge/Activate Timing Guard

This block watches the command stream sent to a multi-bank DRAM and keeps, for each bank, a small timing state: whether the bank is closed, open, waiting for an automatic close after a read, or recovering from a close. From that state it drives two registered per-bank flags. One says that a close (precharge) may be issued on the next clock edge. The other says that an open (activate) may be issued on the next clock edge. A controller can use the flags to schedule commands, or leave the block as a passive monitor.

Timing limits are configured in picoseconds together with the clock period. On a configuration load, an iterative divider turns each limit into a whole number of clock cycles, rounding up. It does this once, so the per-cycle logic only compares small counters. A read that carries an automatic close is modelled as an internal close. That close is placed on the first edge at which an explicit close would not cut the burst short. If the minimum open time has not yet run out at that edge, the internal close waits until it has.

A command that breaks the rules is dropped and has no effect on the bank. The first such command is recorded in a sticky flag, together with the bank number and the kind of command that broke the rule.

Top module: `bank_timing_guard`

## Requirements
- R1: After synchronous reset, every bit of `act_ok` and `pre_ok` is 1, `viol_seen` is 0 and `cfg_ready` is 1.
- R2: Pulsing `cfg_load` converts `cfg_trp_ps` and `cfg_tras_ps` into cycle counts equal to the value divided by `cfg_tck_ps`, rounded up to a whole cycle, with a minimum of 1. `cfg_ready` is 0 from the edge after the load until the conversion ends, and is 1 again within 40 cycles.
- R3: After an activate is accepted for bank b on edge t, `pre_ok[b]` is 0 until edge t+tRAS_cyc-1 and is 1 after it, so that a precharge on edge t+tRAS_cyc is legal.
- R4: After a precharge of bank b starts on edge p, whether explicit or internal, `act_ok[b]` becomes 1 after edge p+tRP_cyc-1 and is 0 before then.
- R5: A read with automatic close (`cmd_op`=3) to an open bank starts the internal precharge on edge r+max(1, BL/2), where r is the edge of the read. If tRAS is not met by that edge, the precharge starts on the first edge at which it is met. Between the read and that edge, `pre_ok` and `act_ok` for the bank are 0.
- R6: A plain read (`cmd_op`=2) has no effect on either flag. A read of either kind to a bank that is not open has no effect.
- R7: An activate while `act_ok[b]`=0, or a precharge while `pre_ok[b]`=0, is ignored by the bank. If `viol_seen` is 0, such a command sets `viol_seen`=1, `viol_bank`=b and `viol_is_pre` (1 for a precharge, 0 for an activate). These three outputs hold until reset.
- R8: Each of the NUM_BANKS banks (4 by default) keeps its own counters. A command changes only the bank selected by `cmd_bank`.
- R9: Opcode encoding on `cmd_op`: 0 idle, 1 activate, 2 read, 3 read with automatic close, 4 precharge. Values 5 to 7 are treated as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every command takes effect on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Single-cycle strobe that captures the configuration and starts conversion |
| cfg_trp_ps | input | PS_W | Close-to-open recovery time in ps |
| cfg_tras_ps | input | PS_W | Minimum open-to-close time in ps |
| cfg_tck_ps | input | PS_W | Clock period in ps (nonzero) |
| cfg_burst_len | input | BL_W | Read burst length in data beats |
| cfg_ready | output | 1 | Conversion idle; cycle counts are valid |
| cmd_op | input | 3 | Command opcode (see R9) |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| act_ok | output | NUM_BANKS | Per bank: an activate on the next edge is legal |
| pre_ok | output | NUM_BANKS | Per bank: a precharge on the next edge is legal |
| viol_seen | output | 1 | Sticky flag: a rule-breaking command was seen |
| viol_bank | output | BANK_W | Bank of the first rule-breaking command |
| viol_is_pre | output | 1 | First violation was a precharge (1) or an activate (0) |

## Verification
The in-line assertions check several properties on every cycle:
- an accepted activate closes that bank's activate window;
- a rising `act_ok` always comes from a recovering bank or from a close that starts on that edge;
- a dropped early precharge leaves the bank open;
- the violation record never changes once it is set;
- a configuration load always drops `cfg_ready`.

The exact cycle positions need the bench's scenarios to show them. These are the round-up of the picosecond limits, the deferral of an automatic close behind tRAS, and the recovery edges. The bench also shows that ignored reads and opcodes leave other banks untouched.

// File: rtl/bank_timing_pkg.sv
package bank_timing_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_RDAP = 3'd3,
    OP_PRE  = 3'd4
  } cmd_op_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPEN    = 2'd1,
    BK_APWAIT  = 2'd2,
    BK_CLOSING = 2'd3
  } bank_st_e;
endpackage

// File: rtl/ceil_divider.sv
// Restoring divider, one quotient bit per cycle; result held until next start.
module ceil_divider #(
  parameter int NW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [NW-1:0] den,
  output logic          busy,
  output logic [NW-1:0] res
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] q_q, q_n;
  logic [NW:0]   rem_q, rem_n, dv_q, shifted;
  logic [NW+1:0] diff;
  logic [CW-1:0] cnt_q;

  always_comb begin
    shifted = {rem_q[NW-1:0], q_q[NW-1]};
    diff    = {1'b0, shifted} - {1'b0, dv_q};
    rem_n   = diff[NW+1] ? shifted : diff[NW:0];
    q_n     = {q_q[NW-2:0], ~diff[NW+1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      q_q   <= '0;
      rem_q <= '0;
      dv_q  <= '0;
      res   <= NW'(1);
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= CW'(NW);
      q_q   <= num;
      rem_q <= '0;
      dv_q  <= {1'b0, den};
    end else if (busy) begin
      q_q   <= q_n;
      rem_q <= rem_n;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy <= 1'b0;
        res  <= q_n;
      end
    end
  end

  p_busy_has_steps_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q != '0));
endmodule

// File: rtl/bank_timer.sv
// Timing state for one bank: open window, autoprecharge wait, recovery.
module bank_timer
  import bank_timing_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_act,
  input  logic             do_rdap,
  input  logic             do_pre,
  input  logic [CNT_W-1:0] trp_cyc,
  input  logic [CNT_W-1:0] tras_cyc,
  input  logic [CNT_W-1:0] ap_half,
  output logic             act_ok_q,
  output logic             pre_ok_q,
  output logic             bad_cmd,
  output logic             bad_is_pre
);
  bank_st_e         st_q, st_n;
  logic [CNT_W-1:0] ras_q, ras_n, rp_q, rp_n, ap_q, ap_n;
  logic             start_pre;

  always_comb begin
    st_n      = st_q;
    ras_n     = (ras_q != '0) ? ras_q - 1'b1 : '0;
    ap_n      = (ap_q != '0) ? ap_q - 1'b1 : '0;
    rp_n      = rp_q;
    start_pre = 1'b0;
    unique case (st_q)
      BK_IDLE: begin
        if (do_act) begin
          st_n  = BK_OPEN;
          ras_n = tras_cyc - 1'b1;
        end
      end
      BK_OPEN: begin
        if (do_pre && ras_q == '0) begin
          start_pre = 1'b1;
        end else if (do_rdap) begin
          st_n = BK_APWAIT;
          ap_n = ap_half - 1'b1;
        end
      end
      BK_APWAIT: begin
        // earliest non-truncating edge reached and tRAS met
        if (ap_q == '0 && ras_q == '0) start_pre = 1'b1;
      end
      BK_CLOSING: begin
        if (rp_q <= CNT_W'(1)) begin
          st_n = BK_IDLE;
          rp_n = '0;
        end else begin
          rp_n = rp_q - 1'b1;
        end
      end
      default: st_n = BK_IDLE;
    endcase
    if (start_pre) begin
      if (trp_cyc <= CNT_W'(1)) begin
        st_n = BK_IDLE;
        rp_n = '0;
      end else begin
        st_n = BK_CLOSING;
        rp_n = trp_cyc - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= BK_IDLE;
      ras_q    <= '0;
      rp_q     <= '0;
      ap_q     <= '0;
      act_ok_q <= 1'b1;
      pre_ok_q <= 1'b1;
    end else begin
      st_q     <= st_n;
      ras_q    <= ras_n;
      rp_q     <= rp_n;
      ap_q     <= ap_n;
      act_ok_q <= (st_n == BK_IDLE);
      pre_ok_q <= (st_n == BK_OPEN) ? (ras_n == '0) : (st_n != BK_APWAIT);
    end
  end

  assign bad_cmd    = (do_act && !act_ok_q) || (do_pre && !pre_ok_q);
  assign bad_is_pre = do_pre && !pre_ok_q;

  p_act_closes_window_r3: assert property (@(posedge clk) disable iff (rst)
    (do_act && act_ok_q) |=> !act_ok_q);

  p_open_only_after_close_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(act_ok_q) |-> $past(st_q == BK_CLOSING || start_pre));

  p_rdap_blocks_both_r5: assert property (@(posedge clk) disable iff (rst)
    (do_rdap && st_q == BK_OPEN && !(do_pre && ras_q == '0)) |=> (!pre_ok_q && !act_ok_q));

  p_early_pre_dropped_r7: assert property (@(posedge clk) disable iff (rst)
    (do_pre && !pre_ok_q && st_q == BK_OPEN && !do_rdap) |=> (st_q == BK_OPEN));
endmodule

// File: rtl/bank_timing_guard.sv
module bank_timing_guard
  import bank_timing_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int PS_W      = 16,
  parameter int CNT_W     = 8,
  parameter int BL_W      = 5,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_load,
  input  logic [PS_W-1:0]      cfg_trp_ps,
  input  logic [PS_W-1:0]      cfg_tras_ps,
  input  logic [PS_W-1:0]      cfg_tck_ps,
  input  logic [BL_W-1:0]      cfg_burst_len,
  output logic                 cfg_ready,
  input  logic [2:0]           cmd_op,
  input  logic [BANK_W-1:0]    cmd_bank,
  output logic [NUM_BANKS-1:0] act_ok,
  output logic [NUM_BANKS-1:0] pre_ok,
  output logic                 viol_seen,
  output logic [BANK_W-1:0]    viol_bank,
  output logic                 viol_is_pre
);
  localparam int NW = PS_W + 1;

  function automatic logic [CNT_W-1:0] to_cycles(input logic [NW-1:0] q);
    if (|q[NW-1:CNT_W])            return '1;
    else if (q[CNT_W-1:0] == '0)   return CNT_W'(1);
    else                           return q[CNT_W-1:0];
  endfunction

  logic [NW-1:0]    trp_num, tras_num, tck_den, trp_res, tras_res;
  logic             trp_busy, tras_busy;
  logic [CNT_W-1:0] trp_cyc, tras_cyc, ap_half_q;

  assign tck_den  = NW'(cfg_tck_ps);
  assign trp_num  = NW'(cfg_trp_ps) + tck_den - NW'(1);
  assign tras_num = NW'(cfg_tras_ps) + tck_den - NW'(1);

  ceil_divider #(.NW(NW)) u_div_trp (
    .clk(clk), .rst(rst), .start(cfg_load),
    .num(trp_num), .den(tck_den), .busy(trp_busy), .res(trp_res)
  );

  ceil_divider #(.NW(NW)) u_div_tras (
    .clk(clk), .rst(rst), .start(cfg_load),
    .num(tras_num), .den(tck_den), .busy(tras_busy), .res(tras_res)
  );

  assign trp_cyc   = to_cycles(trp_res);
  assign tras_cyc  = to_cycles(tras_res);
  assign cfg_ready = !(trp_busy || tras_busy);

  // half-beats per clock: burst occupies max(1, BL/2) cycles
  always_ff @(posedge clk) begin
    if (rst)                ap_half_q <= CNT_W'(1);
    else if (cfg_load)      ap_half_q <= (cfg_burst_len < BL_W'(4)) ? CNT_W'(1)
                                         : CNT_W'(cfg_burst_len >> 1);
  end

  logic [NUM_BANKS-1:0] bad_vec, bad_pre_vec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (cmd_bank == BANK_W'(b));
    bank_timer #(.CNT_W(CNT_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .do_act    (hit && cmd_op == OP_ACT),
      .do_rdap   (hit && cmd_op == OP_RDAP),
      .do_pre    (hit && cmd_op == OP_PRE),
      .trp_cyc   (trp_cyc),
      .tras_cyc  (tras_cyc),
      .ap_half   (ap_half_q),
      .act_ok_q  (act_ok[b]),
      .pre_ok_q  (pre_ok[b]),
      .bad_cmd   (bad_vec[b]),
      .bad_is_pre(bad_pre_vec[b])
    );
  end

  logic [BANK_W-1:0] bad_idx;
  logic              bad_kind;
  always_comb begin
    bad_idx  = '0;
    bad_kind = 1'b0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (bad_vec[i]) begin
        bad_idx  = BANK_W'(i);
        bad_kind = bad_pre_vec[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_seen   <= 1'b0;
      viol_bank   <= '0;
      viol_is_pre <= 1'b0;
    end else if (!viol_seen && |bad_vec) begin
      viol_seen   <= 1'b1;
      viol_bank   <= bad_idx;
      viol_is_pre <= bad_kind;
    end
  end

  p_viol_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    viol_seen |=> (viol_seen && $stable(viol_bank) && $stable(viol_is_pre)));

  p_early_pre_flagged_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_PRE && !pre_ok[cmd_bank]) |=> viol_seen);

  p_load_drops_ready_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> !cfg_ready);
endmodule

// File: tb/bank_timing_guard_tb.sv
module bank_timing_guard_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_load = 1'b0;
  logic [15:0] cfg_trp_ps = '0, cfg_tras_ps = '0, cfg_tck_ps = 16'd4000;
  logic [4:0] cfg_burst_len = '0;
  logic       cfg_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_bank = '0;
  logic [3:0] act_ok, pre_ok;
  logic       viol_seen, viol_is_pre;
  logic [1:0] viol_bank;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  bank_timing_guard u_dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load),
    .cfg_trp_ps(cfg_trp_ps), .cfg_tras_ps(cfg_tras_ps), .cfg_tck_ps(cfg_tck_ps),
    .cfg_burst_len(cfg_burst_len), .cfg_ready(cfg_ready),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .act_ok(act_ok), .pre_ok(pre_ok),
    .viol_seen(viol_seen), .viol_bank(viol_bank), .viol_is_pre(viol_is_pre)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      bad = bad + 1;
      $display("FAIL watchdog expired act=%0d exp=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] bk);
    cmd_op   = op;
    cmd_bank = bk;
    @(negedge clk);
    cmd_op   = 3'd0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_cfg(input int trp, input int tras, input int tck, input int bl);
    cfg_trp_ps    = 16'(trp);
    cfg_tras_ps   = 16'(tras);
    cfg_tck_ps    = 16'(tck);
    cfg_burst_len = 5'(bl);
    cfg_load      = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    chk("R2 ready low after load", int'(cfg_ready), 0);
    for (int i = 0; i < 40 && !cfg_ready; i++) @(negedge clk);
    chk("R2 ready back", int'(cfg_ready), 1);
  endtask

  // {op, bank, expected act_ok, expected pre_ok}; tRP=4, tRAS=11, BL/2=4 cycles
  localparam logic [12:0] VEC [18] = '{
    {3'd1, 2'd0, 4'b1110, 4'b1110},  // R3 open bank 0
    {3'd1, 2'd1, 4'b1100, 4'b1100},  // R8 open bank 1
    {3'd3, 2'd1, 4'b1100, 4'b1100},  // R5 read+close, deferred by tRAS
    {3'd4, 2'd1, 4'b1100, 4'b1100},  // R7 early precharge, dropped
    {3'd0, 2'd0, 4'b1100, 4'b1100},
    {3'd0, 2'd0, 4'b1100, 4'b1100},
    {3'd0, 2'd0, 4'b1100, 4'b1100},
    {3'd0, 2'd0, 4'b1100, 4'b1100},
    {3'd0, 2'd0, 4'b1100, 4'b1100},
    {3'd0, 2'd0, 4'b1100, 4'b1100},
    {3'd0, 2'd0, 4'b1100, 4'b1101},  // R3 bank 0 tRAS=ceil(42000/4000)=11
    {3'd4, 2'd0, 4'b1100, 4'b1101},  // R4 explicit close bank 0
    {3'd0, 2'd0, 4'b1100, 4'b1111},  // R5 internal close bank 1 at tRAS
    {3'd0, 2'd0, 4'b1100, 4'b1111},
    {3'd0, 2'd0, 4'b1101, 4'b1111},  // R4 bank 0 tRP=ceil(15000/4000)=4
    {3'd0, 2'd0, 4'b1111, 4'b1111},  // R5 bank 1 reopenable
    {3'd1, 2'd2, 4'b1011, 4'b1011},  // R8 bank 2 only
    {3'd2, 2'd2, 4'b1011, 4'b1011}   // R6 plain read no effect
  };

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 act_ok reset", int'(act_ok), 'hF);
    chk("R1 pre_ok reset", int'(pre_ok), 'hF);
    chk("R1 viol reset", int'(viol_seen), 0);
    chk("R1 cfg_ready reset", int'(cfg_ready), 1);

    load_cfg(15000, 42000, 4000, 8);
    for (int i = 0; i < 18; i++) begin
      issue(VEC[i][12:10], VEC[i][9:8]);
      chk($sformatf("R3/R4/R5 row %0d act_ok", i), int'(act_ok), int'(VEC[i][7:4]));
      chk($sformatf("R3/R4/R5 row %0d pre_ok", i), int'(pre_ok), int'(VEC[i][3:0]));
    end
    chk("R7 viol_seen", int'(viol_seen), 1);
    chk("R7 viol_bank", int'(viol_bank), 1);
    chk("R7 viol_is_pre", int'(viol_is_pre), 1);

    // tRP=ceil(8001/4000)=3, tRAS=8000/4000=2 exact, BL=4 -> 2 cycles
    do_reset();
    load_cfg(8001, 8000, 4000, 4);
    issue(3'd1, 2'd3);
    chk("R3 exact tRAS not yet", int'(pre_ok[3]), 0);
    issue(3'd0, 2'd0);
    chk("R3 exact tRAS met", int'(pre_ok[3]), 1);
    issue(3'd3, 2'd3);
    chk("R5 rdap blocks pre", int'(pre_ok[3]), 0);
    issue(3'd0, 2'd0);
    chk("R5 before close pre", int'(pre_ok[3]), 0);
    issue(3'd0, 2'd0);
    chk("R5 close at BL/2 pre", int'(pre_ok[3]), 1);
    chk("R5 close at BL/2 act", int'(act_ok[3]), 0);
    issue(3'd0, 2'd0);
    chk("R4 tRP=3 not yet", int'(act_ok[3]), 0);
    issue(3'd0, 2'd0);
    chk("R4 tRP=3 reached", int'(act_ok[3]), 1);
    chk("R8 others untouched", int'(act_ok[2:0]), 7);

    // R6 reads to closed banks; R9 undefined opcode
    issue(3'd2, 2'd0);
    issue(3'd3, 2'd1);
    issue(3'd7, 2'd2);
    issue(3'd0, 2'd0);
    issue(3'd0, 2'd0);
    chk("R6 R9 act_ok unchanged", int'(act_ok), 'hF);
    chk("R6 R9 pre_ok unchanged", int'(pre_ok), 'hF);
    chk("R9 no violation", int'(viol_seen), 0);

    // R7 early activate
    issue(3'd1, 2'd2);
    issue(3'd1, 2'd2);
    chk("R7 act viol seen", int'(viol_seen), 1);
    chk("R7 act viol bank", int'(viol_bank), 2);
    chk("R7 act viol kind", int'(viol_is_pre), 0);
    chk("R7 bank stays open", int'(act_ok[2]), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule